// File: doc/BRIEF.md
# Remote I/O Port with Edge-Event Reporting

This block is the digital pin port of a serial-bus remote I/O node. It offers a parameterised number of general-purpose pins, 16 by default. Each pin is either driven from an output data register or released to high impedance. Released pins can be watched for rising and/or falling transitions. When a watched transition happens, the block raises a transmit request toward the bus protocol engine. The engine answers with a strobe when the outgoing frame's control field has gone out. Only then does the block copy the synchronised pin levels into the transmit word. The late copy lets inputs settle, so the word reports the levels at copy time, not at detection time.

Configuration arrives from received frames. The protocol engine stages an address/data pair into the block. The pair takes effect only when the engine pulses a commit strobe, which tells the block that the carrying frame was checked and valid. Two other sources also raise a transmit request: an explicit read request, and a one-shot sign-on. The sign-on is armed by a wake-up or bus-mode-change event and fires once the bit timing is reported calibrated.

Top module: `rio_port`

## Requirements
- R1: After reset, `pin_oe`, `pin_out`, `tx_req` and `tx_word` are all zero. All edge enables are zero.
- R2: A staged write changes nothing until `frame_ok` is pulsed. After the clock edge that samples `frame_ok`, the staged value is in its register. Address 1 is the rising-edge enable, 2 the falling-edge enable, 3 the output data and 4 the output enable. Bit n of each register belongs to pin n.
- R3: `pin_oe` equals the output-enable register. `pin_out` bit n equals output data bit n where output-enable bit n is 1, and is 0 where it is 0, meaning the pin is released.
- R4: A committed write to address 0 (the read-only input word) or to addresses 5 to 7 changes no register.
- R5: A low-to-high change on a pin with rising enable 1 and output enable 0 sets `tx_req` at the third rising clock edge after the change. It does not set it at the second.
- R6: A high-to-low change on a pin with falling enable 1 and output enable 0 sets `tx_req` the same way. A pin with both enables set reports both directions.
- R7: A transition on a pin whose enable for that direction is 0, or whose output enable is 1, never sets `tx_req`.
- R8: `ctl_sent` while `tx_req` is 1 loads `tx_word` with `in_level` as it stood at that edge and clears `tx_req`. A pin that changed after detection is therefore reported at its newer level.
- R9: Edges that occur while `tx_req` is already 1 create no further request. After the snapshot, `tx_req` stays 0.
- R10: A one-cycle `rd_req` sets `tx_req` at the next clock edge.
- R11: A `wake_evt` pulse arms a sign-on. `tx_req` is set one edge after `timing_cal` is seen high while armed, and this happens only once per wake event. `timing_cal` without a prior wake event has no effect.
- R12: `in_level` follows `pin_in` through two register stages: a change appears after exactly two rising edges.
- R13: `ctl_sent` while `tx_req` is 0 leaves `tx_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | N | Raw pin levels from the pads |
| pin_out | output | N | Pad output data, masked to 0 on released pins |
| pin_oe | output | N | Pad driver enable, 1 drives the pin |
| wr_vld | input | 1 | Stage one register write from a received payload |
| wr_addr | input | 3 | Register address of the staged write |
| wr_data | input | N | Data of the staged write |
| frame_ok | input | 1 | Commit strobe: carrying frame validated |
| rd_req | input | 1 | Explicit request to send the input word |
| wake_evt | input | 1 | Wake-up or bus-mode-change pulse, arms sign-on |
| timing_cal | input | 1 | Bit timing calibrated level |
| ctl_sent | input | 1 | Control field of the pending frame sent, take snapshot |
| tx_req | output | 1 | Transmit request pending |
| tx_word | output | N | Snapshot of input levels for transmission |
| in_level | output | N | Synchronised pin levels (readable input word) |

## Verification
The bench builds the block with its defaults: 16 pins and a two-stage synchroniser. With these values every pin can be swept through five configurations: rising only, falling only, both, none, and driven as output. Each sweep point tries both transition directions, so the edge enables and the output masking are covered for each pin index. The expected request state and snapshot word are derived from the pin index and mode. The two-stage depth makes the detection latency a fixed three edges, so the bench can probe the cycle before and the cycle of the request. It also covers a level that changes between detection and snapshot, and the staging, commit and sign-on sequences.

// File: rtl/rio_pkg.sv
package rio_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RIO_A_INPUT = 3'd0,
      RIO_A_RISE  = 3'd1,
      RIO_A_FALL  = 3'd2,
      RIO_A_DOUT  = 3'd3,
      RIO_A_OE    = 3'd4
   } rio_addr_e;
endpackage

// File: rtl/rio_sync.sv
module rio_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("rio_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rio_regfile.sv
module rio_regfile
   import rio_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_vld,
   input  logic [ADDR_W-1:0] stage_addr,
   input  logic [W-1:0]      stage_data,
   input  logic              commit,
   output logic [W-1:0]      rise_en,
   output logic [W-1:0]      fall_en,
   output logic [W-1:0]      dout,
   output logic [W-1:0]      oe
);
   logic              pend_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [W-1:0]      pend_data_q;
   logic              apply;

   assign apply = commit & pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
         pend_data_q <= '0;
      end else begin
         if (stage_vld) begin
            pend_q      <= 1'b1;
            pend_addr_q <= stage_addr;
            pend_data_q <= stage_data;
         end else if (commit) begin
            pend_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en <= '0;
         fall_en <= '0;
         dout    <= '0;
         oe      <= '0;
      end else if (apply) begin
         case (rio_addr_e'(pend_addr_q))
            RIO_A_RISE: rise_en <= pend_data_q;
            RIO_A_FALL: fall_en <= pend_data_q;
            RIO_A_DOUT: dout    <= pend_data_q;
            RIO_A_OE:   oe      <= pend_data_q;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rio_edge.sv
module rio_edge #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] oe,
   output logic         hit
);
   logic [W-1:0] lvl_d;
   logic [W-1:0] pin_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end

   generate
      for (genvar g = 0; g < W; g++) begin : g_pin
         logic up, dn;
         assign up = lvl[g] & ~lvl_d[g] & rise_en[g];
         assign dn = ~lvl[g] & lvl_d[g] & fall_en[g];
         assign pin_hit[g] = (up | dn) & ~oe[g];
      end
   endgenerate

   assign hit = |pin_hit;
endmodule

// File: rtl/rio_txctl.sv
module rio_txctl #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  logic         rd_req,
   input  logic         wake_evt,
   input  logic         timing_cal,
   input  logic         ctl_sent,
   input  logic [W-1:0] lvl,
   output logic         req_set,
   output logic         tx_req,
   output logic [W-1:0] tx_word
);
   logic armed_q;
   logic signon;
   logic snap;

   assign signon  = armed_q & timing_cal;
   assign req_set = hit | rd_req | signon;
   assign snap    = tx_req & ctl_sent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         tx_req  <= 1'b0;
         tx_word <= '0;
      end else begin
         armed_q <= (armed_q | wake_evt) & ~signon;
         tx_req  <= (tx_req & ~ctl_sent) | req_set;
         if (snap) tx_word <= lvl;
      end
   end
endmodule

// File: rtl/rio_port.sv
module rio_port
   import rio_pkg::*;
#(
   parameter int unsigned N           = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      pin_in,
   output logic [N-1:0]      pin_out,
   output logic [N-1:0]      pin_oe,
   input  logic              wr_vld,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N-1:0]      wr_data,
   input  logic              frame_ok,
   input  logic              rd_req,
   input  logic              wake_evt,
   input  logic              timing_cal,
   input  logic              ctl_sent,
   output logic              tx_req,
   output logic [N-1:0]      tx_word,
   output logic [N-1:0]      in_level
);
   generate
      if (N < 1 || N > 32) begin : g_bad_n
         $error("rio_port: N must be in 1..32");
      end
   endgenerate

   logic [N-1:0] rise_en, fall_en, dout, oe;
   logic         hit;
   logic         req_set;

   rio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_level)
   );

   rio_regfile #(.W(N)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .stage_vld(wr_vld), .stage_addr(wr_addr), .stage_data(wr_data),
      .commit(frame_ok),
      .rise_en(rise_en), .fall_en(fall_en), .dout(dout), .oe(oe)
   );

   rio_edge #(.W(N)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(in_level),
      .rise_en(rise_en), .fall_en(fall_en), .oe(oe), .hit(hit)
   );

   rio_txctl #(.W(N)) u_tx (
      .clk(clk), .rst_n(rst_n), .hit(hit), .rd_req(rd_req),
      .wake_evt(wake_evt), .timing_cal(timing_cal), .ctl_sent(ctl_sent),
      .lvl(in_level), .req_set(req_set), .tx_req(tx_req), .tx_word(tx_word)
   );

   assign pin_oe  = oe;
   assign pin_out = dout & oe;
endmodule

// File: rtl/rio_port_chk.sv
module rio_port_chk #(
   parameter int unsigned N           = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] pin_in,
   input logic [N-1:0] pin_oe,
   input logic         frame_ok,
   input logic         ctl_sent,
   input logic         req_set,
   input logic         tx_req,
   input logic [N-1:0] tx_word,
   input logic [N-1:0] in_level
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R2: register outputs only move on a commit
   assert_commit_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !frame_ok) |=> $stable(pin_oe));

   // R8: snapshot word equals synchronised levels at the strobe edge
   assert_snap_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && ctl_sent) |=> (tx_word == $past(in_level)));

   // R8: request cleared by snapshot when nothing new arrives
   assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && ctl_sent && !req_set) |=> !tx_req);

   // R9: pending request holds until the snapshot strobe
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !ctl_sent) |=> tx_req);

   // R13: tx_word unchanged without a pending snapshot
   assert_word_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !(tx_req && ctl_sent)) |=> $stable(tx_word));

   generate
      if (SYNC_STAGES == 2) begin : g_lat
         // R12: two-stage input latency
         assert_sync_lat_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3) |-> (in_level == $past(pin_in, 2)));
      end
   endgenerate
endmodule

bind rio_port rio_port_chk #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(pin_oe),
   .frame_ok(frame_ok), .ctl_sent(ctl_sent), .req_set(req_set),
   .tx_req(tx_req), .tx_word(tx_word), .in_level(in_level)
);

// File: tb/rio_port_bench.sv
module rio_port_bench;
   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out, pin_oe, tx_word, in_level;
   logic         wr_vld = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [N-1:0] wr_data = '0;
   logic         frame_ok = 1'b0, rd_req = 1'b0, wake_evt = 1'b0;
   logic         timing_cal = 1'b0, ctl_sent = 1'b0;
   logic         tx_req;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rio_port #(.N(N), .SYNC_STAGES(2)) u_rio_port (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
      .frame_ok(frame_ok), .rd_req(rd_req), .wake_evt(wake_evt),
      .timing_cal(timing_cal), .ctl_sent(ctl_sent), .tx_req(tx_req),
      .tx_word(tx_word), .in_level(in_level)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input logic [2:0] a, input logic [N-1:0] d);
      wr_vld = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_vld = 1'b0;
      frame_ok = 1'b1;
      tick(1);
      frame_ok = 1'b0;
   endtask

   task automatic snap();
      ctl_sent = 1'b1;
      tick(1);
      ctl_sent = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1
      chk("R1 pin_oe", 32'(pin_oe), 0);
      chk("R1 pin_out", 32'(pin_out), 0);
      chk("R1 tx_req", 32'(tx_req), 0);
      chk("R1 tx_word", 32'(tx_word), 0);

      // R12: latency of the synchroniser
      pin_in = 16'h3C5A;
      tick(1);
      chk("R12 one edge", 32'(in_level), 0);
      tick(1);
      chk("R12 two edges", 32'(in_level), 32'h3C5A);
      pin_in = '0;
      tick(3);

      // R2: staged but not committed
      wr_vld = 1'b1; wr_addr = 3'd4; wr_data = 16'hFFFF;
      tick(1);
      wr_vld = 1'b0;
      tick(4);
      chk("R2 staged no effect", 32'(pin_oe), 0);
      frame_ok = 1'b1;
      tick(1);
      frame_ok = 1'b0;
      chk("R2 committed oe", 32'(pin_oe), 32'hFFFF);

      // R3
      put(3'd3, 16'hA5A5);
      put(3'd4, 16'h00FF);
      chk("R3 pin_oe", 32'(pin_oe), 32'h00FF);
      chk("R3 pin_out masked", 32'(pin_out), 32'h00A5);

      // R4
      put(3'd0, 16'hFFFF);
      put(3'd6, 16'h1234);
      put(3'd7, 16'h0000);
      put(3'd5, 16'hFFFF);
      chk("R4 oe unchanged", 32'(pin_oe), 32'h00FF);
      chk("R4 out unchanged", 32'(pin_out), 32'h00A5);
      // rising enables still 0: an input edge must raise nothing
      put(3'd4, 16'h0000);
      pin_in[9] = 1'b1;
      tick(4);
      chk("R4 rise_en unchanged", 32'(tx_req), 0);
      pin_in = '0;
      tick(3);

      // R5, R6, R7, R8 sweep over pins and modes
      for (int p = 0; p < N; p++) begin
         for (int m = 0; m < 5; m++) begin
            logic [N-1:0] b;
            logic er, ef;
            b  = N'(1) << p;
            er = (m == 0 || m == 2);
            ef = (m == 1 || m == 2);
            put(3'd1, (m == 4) ? '1 : (er ? b : '0));
            put(3'd2, (m == 4) ? '1 : (ef ? b : '0));
            put(3'd4, (m == 4) ? b : '0);
            snap();
            pin_in = b;
            tick(2);
            chk("R5 not yet at 2nd edge", 32'(tx_req), 0);
            tick(1);
            chk(er ? "R5 rise request" : "R7 rise ignored", 32'(tx_req), 32'(er));
            if (er) begin
               tick(1);
               snap();
               chk("R8 snapshot high", 32'(tx_word), 32'(b));
               chk("R8 cleared", 32'(tx_req), 0);
            end
            pin_in = '0;
            tick(3);
            chk(ef ? "R6 fall request" : "R7 fall ignored", 32'(tx_req), 32'(ef));
            if (ef) begin
               snap();
               chk("R8 snapshot low", 32'(tx_word), 0);
            end
            tick(1);
         end
      end

      // R8/R9: level changes between detection and snapshot
      put(3'd1, 16'h0008);
      put(3'd2, 16'h0008);
      put(3'd4, 16'h0000);
      pin_in = 16'h0088;
      tick(3);
      chk("R5 pin3 request", 32'(tx_req), 1);
      pin_in = 16'h0080;
      tick(4);
      snap();
      chk("R8 newer level reported", 32'(tx_word), 32'h0080);
      tick(4);
      chk("R9 no second request", 32'(tx_req), 0);

      // R13
      snap();
      chk("R13 word kept", 32'(tx_word), 32'h0080);
      pin_in = '0;
      put(3'd1, 16'h0000);
      put(3'd2, 16'h0000);
      tick(3);

      // R10
      rd_req = 1'b1;
      tick(1);
      rd_req = 1'b0;
      chk("R10 read request", 32'(tx_req), 1);
      pin_in = 16'h1001;
      tick(3);
      snap();
      chk("R10 snapshot", 32'(tx_word), 32'h1001);

      // R11
      timing_cal = 1'b1;
      tick(3);
      chk("R11 cal without wake", 32'(tx_req), 0);
      timing_cal = 1'b0;
      wake_evt = 1'b1;
      tick(1);
      wake_evt = 1'b0;
      tick(3);
      chk("R11 armed waits for cal", 32'(tx_req), 0);
      timing_cal = 1'b1;
      tick(1);
      chk("R11 sign-on request", 32'(tx_req), 1);
      snap();
      chk("R11 sign-on word", 32'(tx_word), 32'h1001);
      tick(5);
      chk("R11 only once", 32'(tx_req), 0);
      timing_cal = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule